// File: doc/BRIEF.md
# Condition Register Field Move Unit

This block holds a 32-bit condition register organised as eight 4-bit fields and carries out the single-field move-to-condition-register operation. Each request brings an 8-bit field mask operand and a 64-bit source register value, qualified by a valid strobe. The unit first converts the mask operand into a field number and then converts that number back into a one-hot write mask. As a result, exactly one field is written on every accepted request, whatever the operand holds. The chosen nibble is replaced with the nibble at the same bit position of the source's low 32 bits, and the other seven nibbles keep their values.

A zero mask operand does not cancel the write. It selects the lowest-order field, which sits in bits 3:0. When several mask bits are set, the most significant set bit wins. The register value is always visible on `cr_value`. The write mask that was applied, together with a strobe, appears on the same cycle as the updated register value, one cycle after the request, so that a trace or a checker can follow each update.

Top module: `crf_move_unit`

## Requirements
- R1: While reset is held and after its release, `cr_value` is 0, `applied_mask` is 0 and `applied_valid` is 0 until the first accepted request.
- R2: A request accepted on a rising edge with `field_mask` bit i as the only set bit replaces `cr_value` bits [4i+3:4i] with `src_value` bits [4i+3:4i]. Bit 7 selects bits 31:28 and bit 0 selects bits 3:0.
- R3: A request with `field_mask` equal to 0 applies write mask 8'h01 and replaces `cr_value` bits 3:0.
- R4: When more than one `field_mask` bit is set, only the field of the most significant set bit is written, and `applied_mask` is that single bit.
- R5: The seven nibbles not selected by the applied write mask keep their previous values.
- R6: `src_value` bits 63:32 have no effect on `cr_value`.
- R7: While `req_valid` is low, `cr_value` does not change and `applied_valid` is low on the next cycle.
- R8: `applied_valid` is high exactly in the cycle after a request is accepted. In that cycle `applied_mask` has exactly one bit set, and `cr_value` already shows the update.
- R9: From a register value of 32'h3F089F7F, a request with source 32'h0001C020 and `field_mask` 0 produces 32'h3F089F70.
- R10: Requests on consecutive cycles are each applied in order, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request strobe; the write is taken on the rising edge where it is high |
| field_mask | input | 8 | Field mask operand; bit 7 is the field at bits 31:28 |
| src_value | input | 64 | Source register; only bits 31:0 supply field data |
| cr_value | output | 32 | Current condition register value |
| applied_mask | output | 8 | One-hot write mask of the last accepted request |
| applied_valid | output | 1 | High in the cycle after an accepted request |

## Verification
The hardest situation to reach from the ports is a multi-bit mask whose losing fields would visibly change the register if they were written wrongly. A write that hits an extra field is invisible whenever the source nibble equals the old nibble there. The bench therefore first fills the register with a known pattern of distinct nibbles. It then applies multi-bit masks with sources that differ from the current value in every nibble, so that a write to any wrong field shows up in the compared value. Random masks are drawn with a bias towards zero and multi-bit values and are interleaved with idle cycles.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int CRF_NFIELDS = 8;
  localparam int CRF_FIELD_W = 4;
  localparam int CRF_CR_W    = CRF_NFIELDS * CRF_FIELD_W;
  localparam int CRF_SRC_W   = 64;
  localparam int CRF_NUM_W   = $clog2(CRF_NFIELDS);

  typedef logic [CRF_NFIELDS-1:0] crf_mask_t;
  typedef logic [CRF_CR_W-1:0]    crf_word_t;
  typedef logic [CRF_NUM_W-1:0]   crf_num_t;

  // Widen a per-field mask into a per-bit mask over the register.
  function automatic crf_word_t crf_expand(crf_mask_t m);
    crf_word_t w;
    for (int i = 0; i < CRF_NFIELDS; i++) begin
      w[i*CRF_FIELD_W +: CRF_FIELD_W] = {CRF_FIELD_W{m[i]}};
    end
    return w;
  endfunction
endpackage

// File: rtl/crf_rst_sync.sv
module crf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/crf_mask_to_num.sv
// Field mask operand to field number. Field number f maps to mask bit
// NFIELDS-1-f. The most significant set bit wins; an empty mask yields
// the highest field number (the field in the lowest-order bits).
module crf_mask_to_num #(
  parameter int NFIELDS = 8,
  localparam int NUM_W  = $clog2(NFIELDS)
) (
  input  logic [NFIELDS-1:0] mask_i,
  output logic [NUM_W-1:0]   num_o
);
  always_comb begin
    num_o = NUM_W'(NFIELDS - 1);
    for (int i = 0; i < NFIELDS; i++) begin
      if (mask_i[i]) begin
        num_o = NUM_W'(NFIELDS - 1 - i);
      end
    end
  end
endmodule

// File: rtl/crf_num_to_mask.sv
// Field number to one-hot write mask.
module crf_num_to_mask #(
  parameter int NFIELDS = 8,
  localparam int NUM_W  = $clog2(NFIELDS)
) (
  input  logic [NUM_W-1:0]   num_i,
  output logic [NFIELDS-1:0] mask_o
);
  for (genvar g = 0; g < NFIELDS; g++) begin : g_dec
    assign mask_o[g] = (num_i == NUM_W'(NFIELDS - 1 - g));
  end
endmodule

// File: rtl/crf_nibble_merge.sv
// Per-field select between the held value and the source.
module crf_nibble_merge #(
  parameter int NFIELDS = 8,
  parameter int FIELD_W = 4,
  localparam int CR_W   = NFIELDS * FIELD_W
) (
  input  logic [CR_W-1:0]    cur_i,
  input  logic [CR_W-1:0]    src_i,
  input  logic [NFIELDS-1:0] wmask_i,
  output logic [CR_W-1:0]    merged_o
);
  for (genvar g = 0; g < NFIELDS; g++) begin : g_fld
    assign merged_o[g*FIELD_W +: FIELD_W] =
      wmask_i[g] ? src_i[g*FIELD_W +: FIELD_W] : cur_i[g*FIELD_W +: FIELD_W];
  end
endmodule

// File: rtl/crf_move_unit.sv
module crf_move_unit
  import crf_pkg::*;
#(
  parameter int NFIELDS = CRF_NFIELDS,
  parameter int FIELD_W = CRF_FIELD_W,
  parameter int SRC_W   = CRF_SRC_W,
  localparam int CR_W   = NFIELDS * FIELD_W,
  localparam int NUM_W  = $clog2(NFIELDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [NFIELDS-1:0] field_mask,
  input  logic [SRC_W-1:0]   src_value,
  output logic [CR_W-1:0]    cr_value,
  output logic [NFIELDS-1:0] applied_mask,
  output logic               applied_valid
);
  logic               rst_sync_n;
  logic [NUM_W-1:0]   field_num;
  logic [NFIELDS-1:0] wmask;
  logic [CR_W-1:0]    merged;

  logic [CR_W-1:0]    cr_q,   cr_d;
  logic [NFIELDS-1:0] mask_q, mask_d;
  logic               vld_q,  vld_d;
  logic               upd_en;

  crf_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  crf_mask_to_num #(.NFIELDS(NFIELDS)) u_m2n (
    .mask_i (field_mask),
    .num_o  (field_num)
  );

  crf_num_to_mask #(.NFIELDS(NFIELDS)) u_n2m (
    .num_i  (field_num),
    .mask_o (wmask)
  );

  crf_nibble_merge #(.NFIELDS(NFIELDS), .FIELD_W(FIELD_W)) u_merge (
    .cur_i    (cr_q),
    .src_i    (src_value[CR_W-1:0]),
    .wmask_i  (wmask),
    .merged_o (merged)
  );

  // Next state
  always_comb begin
    upd_en = req_valid;
    cr_d   = merged;
    mask_d = wmask;
    vld_d  = req_valid;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cr_q   <= '0;
      mask_q <= '0;
    end else if (upd_en) begin
      cr_q   <= cr_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign cr_value      = cr_q;
  assign applied_mask  = mask_q;
  assign applied_valid = vld_q;
endmodule

// File: rtl/crf_move_unit_chk.sv
module crf_move_unit_chk
  import crf_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rst_sync_n,
  input logic                   req_valid,
  input logic [CRF_NFIELDS-1:0] field_mask,
  input logic [CRF_SRC_W-1:0]   src_value,
  input logic [CRF_CR_W-1:0]    cr_value,
  input logic [CRF_NFIELDS-1:0] applied_mask,
  input logic                   applied_valid
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else if (rst_sync_n) past_ok <= 1'b1;
  end

  // R1: reset leaves the register cleared
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst_sync_n)
    (cr_value == '0) && !applied_valid);

  // R8: strobe follows an accepted request by one cycle
  assert_strobe_timing_R8: assert property (@(posedge clk) disable iff (!past_ok)
    applied_valid == $past(req_valid));

  // R8: applied mask is one-hot
  assert_mask_onehot_R8: assert property (@(posedge clk) disable iff (!past_ok)
    applied_valid |-> $countones(applied_mask) == 1);

  // R3: empty operand selects the lowest-order field
  assert_zero_mask_R3: assert property (@(posedge clk) disable iff (!past_ok)
    (applied_valid && $past(field_mask) == '0) |-> applied_mask == 8'h01);

  // R4: chosen bit is requested and no higher bit was requested
  assert_priority_R4: assert property (@(posedge clk) disable iff (!past_ok)
    (applied_valid && $past(field_mask) != '0) |->
      (((applied_mask & $past(field_mask)) == applied_mask) &&
       ({1'b0, $past(field_mask)} < {applied_mask, 1'b0})));

  // R2: written field carries the source nibble
  assert_field_data_R2: assert property (@(posedge clk) disable iff (!past_ok)
    applied_valid |-> ((cr_value & crf_expand(applied_mask)) ==
                       ($past(src_value[CRF_CR_W-1:0]) & crf_expand(applied_mask))));

  // R5: unselected fields are untouched
  assert_others_kept_R5: assert property (@(posedge clk) disable iff (!past_ok)
    applied_valid |-> (((cr_value ^ $past(cr_value)) & ~crf_expand(applied_mask)) == '0));

  // R7: idle cycles hold the register
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!past_ok)
    !applied_valid |-> $stable(cr_value));
endmodule

bind crf_move_unit crf_move_unit_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rst_sync_n    (rst_sync_n),
  .req_valid     (req_valid),
  .field_mask    (field_mask),
  .src_value     (src_value),
  .cr_value      (cr_value),
  .applied_mask  (applied_mask),
  .applied_valid (applied_valid)
);

// File: tb/crf_move_unit_bench.sv
module crf_move_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  field_mask;
  logic [63:0] src_value;
  logic [31:0] cr_value;
  logic [7:0]  applied_mask;
  logic        applied_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [31:0] model_cr;

  always #10 clk = ~clk;

  crf_move_unit u_crf_move_unit (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .field_mask    (field_mask),
    .src_value     (src_value),
    .cr_value      (cr_value),
    .applied_mask  (applied_mask),
    .applied_valid (applied_valid)
  );

  // Reference: scan from the top mask bit down; empty mask -> 8'h01.
  function automatic logic [7:0] ref_wmask(logic [7:0] m);
    for (int b = 7; b >= 0; b--) begin
      if (m[b]) return 8'(1 << b);
    end
    return 8'h01;
  endfunction

  function automatic logic [31:0] ref_apply(logic [31:0] cur, logic [63:0] s, logic [7:0] m);
    logic [7:0]  w = ref_wmask(m);
    logic [31:0] r = cur;
    for (int f = 0; f < 8; f++) begin
      if (w[f]) r[f*4 +: 4] = s[f*4 +: 4];
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, sample at the next falling edge.
  task automatic step(bit v, logic [7:0] m, logic [63:0] s, string req);
    req_valid  = v;
    field_mask = m;
    src_value  = s;
    @(posedge clk);
    @(negedge clk);
    if (v) begin
      model_cr = ref_apply(model_cr, s, m);
      check(req, cr_value, model_cr);
      check({req, " mask"}, {24'h0, applied_mask}, {24'h0, ref_wmask(m)});
      check({req, " strobe"}, {31'h0, applied_valid}, 32'h1);
    end else begin
      check({req, " hold"}, cr_value, model_cr);
      check({req, " idle strobe"}, {31'h0, applied_valid}, 32'h0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; req_valid = 1'b0; field_mask = '0; src_value = '0;
    model_cr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    check("R1 cr", cr_value, 32'h0);
    check("R1 strobe", {31'h0, applied_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 cr after release", cr_value, 32'h0);
    check("R1 mask after release", {24'h0, applied_mask}, 32'h0);

    // R2: every one-hot mask, distinct source per field
    for (int b = 0; b < 8; b++) begin
      step(1'b1, 8'(1 << b), {32'hFFFF_FFFF, 32'h9ABC_DEF1 + 32'(b)}, "R2 one-hot");
    end

    // R9: preset the register field by field, then the known case
    for (int b = 7; b >= 0; b--) step(1'b1, 8'(1 << b), 64'h3F08_9F7F, "R9 preset");
    check("R9 preset value", cr_value, 32'h3F089F7F);
    step(1'b1, 8'h00, 64'h0001_C020, "R9 example");
    check("R9 result", cr_value, 32'h3F089F70);

    // R3: zero mask with a full source
    step(1'b1, 8'h00, 64'h0000_0000_8765_432A, "R3 zero mask");

    // R4/R5: multi-bit masks, source differs from current in every nibble
    step(1'b1, 8'hFF, {32'h0, ~cr_value}, "R4 all bits");
    step(1'b1, 8'h81, {32'h0, ~cr_value}, "R4 ends");
    step(1'b1, 8'h03, {32'h0, ~cr_value}, "R4 low pair");
    step(1'b1, 8'h5A, {32'h0, ~cr_value}, "R5 scattered");
    step(1'b1, 8'h24, {32'h0, ~cr_value}, "R5 mid pair");

    // R6: upper source half ignored
    step(1'b1, 8'h10, {32'hFFFF_FFFF, cr_value}, "R6 upper half");
    step(1'b1, 8'h00, {32'hA5A5_A5A5, cr_value}, "R6 upper half zero mask");

    // R7: idle cycles with busy inputs
    step(1'b0, 8'hFF, 64'hDEAD_BEEF_DEAD_BEEF, "R7 idle");
    step(1'b0, 8'h00, 64'h1234_5678_9ABC_DEF0, "R7 idle");

    // R10/R8: random back-to-back traffic with occasional gaps
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  m;
      logic [63:0] s;
      int sel = int'($urandom_range(0, 3));
      case (sel)
        0: m = 8'h00;
        1: m = 8'(1 << $urandom_range(0, 7));
        default: m = 8'($urandom);
      endcase
      s = {$urandom, $urandom};
      step(($urandom_range(0, 4) != 0), m, s, "R10 random");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule